// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous static memory with registered inputs and a registered read path. Every address, data and control input is captured on the rising clock edge. A new access is opened by one of two active-low address strobes: a processor-side strobe, which always starts a read, and a controller-side strobe, which may start either a read or a write. Both strobes capture the address and the two chip-select inputs. After an access is opened, an advance input steps a two-bit burst counter. The counter produces the follow-on word addresses inside the aligned group of four. The step order is linear (start plus count, modulo four) or interleaved (start XOR count), and the burst-order input picks between them.

Writes are layered. A global write stores every byte lane. Without it, a byte-write enable passes the per-lane enables through, so any subset of lanes can be written. Read data leaves through an output register. The data bus is released to high impedance when the access is deselected, during write cycles, or at once, without a clock edge, when the output enable is taken high. The `rd_en_o` output reports whether `rd_q` is being driven.

Top module: `burst_sram`

## Requirements
- R1: After reset no access is open and `rd_en_o` is 0 (`rd_q` floats) until a selected read completes.
- R2: A low `proc_strb_n` loads `addr_i` and the chip selects and starts a read. Write controls sampled in that same cycle are ignored, and the memory content is unchanged.
- R3: A low `ctrl_strb_n` with `proc_strb_n` high loads `addr_i` and the chip selects. The cycle is a write if the write controls request any lane, and a read otherwise. During a write access `rd_en_o` is 0 in the output cycle.
- R4: A read access sampled at clock edge k drives its word on `rd_q` with `rd_en_o`=1 after edge k+1. Consecutive burst reads produce one word per cycle.
- R5: With `burst_linear`=1, the n-th burst word (n counted from 0 at the strobe) is at offset (start + n) mod 4 in address bits [1:0]. Bits above are unchanged, and the sequence wraps after four advances.
- R6: With `burst_linear`=0, the n-th burst word is at offset start XOR n in address bits [1:0].
- R7: With both strobes and `adv_n` high, the burst address is held. An open access reads the same word again, and write controls are ignored in that cycle.
- R8: `glob_wr_n`=0 on a write-eligible cycle (controller strobe start or advance) writes all four lanes, whatever `bw_en_n` and `lane_wr_n` are.
- R9: With `glob_wr_n`=1 and `bw_en_n`=0, only the lanes i with `lane_wr_n[i]`=0 are written. Lane i is data bits [9i+8:9i]. With `bw_en_n`=1 and `glob_wr_n`=1 nothing is written.
- R10: A strobe that samples the chips deselected (the chip is selected only when `sel_n`=0 and `sel_hi`=1) opens no access. `rd_en_o` is 0 after the next edge, and advances before the next strobe do nothing.
- R11: `oe_n`=1 forces `rd_en_o` to 0 and `rd_q` to high impedance immediately, with no clock edge. Returning `oe_n` to 0 restores the registered word.
- R12: A lane never written since reset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Word address, captured on a strobe |
| proc_strb_n | input | 1 | Processor-side address strobe, starts a read, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| glob_wr_n | input | 1 | Global write of all lanes, active low |
| bw_en_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| wr_data | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_q | output | 36 | Read data, high impedance when not driven |
| rd_en_o | output | 1 | 1 while rd_q is driven |

## Verification
The hardest situation to reach from the ports is a burst that visits every offset of a group in both orders, for every starting offset, with the group holding known and distinct words in each slot. The stimulus first fills one group with four different words through a controller-strobe write followed by three advances. It then opens a processor-strobe read at each of the four offsets in each order and advances through the whole group, wrap included. A vector table also mixes partial-lane writes, ignored writes on processor-strobe and hold cycles, and deselected strobes followed by advances. Each cycle is compared against a reference array and an address model, both built from the requirements.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Offset of the current word inside an aligned group of four
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input logic       linear);
    logic [1:0] sum;
    sum = start + cnt;
    return linear ? sum : (start ^ cnt);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              adv_n,
  input  logic              sel_ok,
  input  logic              linear,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_open
);
  import burst_sram_pkg::*;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              act_q, act_d;
  logic              start;

  always_comb begin
    start  = !proc_strb_n || !ctrl_strb_n;
    base_d = base_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (start) begin
      base_d = addr_i;
      cnt_d  = 2'd0;
      act_d  = sel_ok;
    end else if (!adv_n && act_q) begin
      cnt_d  = cnt_q + 2'd1;
    end
    acc_addr = {base_d[ADDR_W-1:2], burst_offset(base_d[1:0], cnt_d, linear)};
    acc_open = act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  // R2
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n || !ctrl_strb_n) |=> (base_q == $past(addr_i)) && (cnt_q == 2'd0));

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_n && ctrl_strb_n && adv_n) |=> $stable(base_q) && $stable(cnt_q));

  // R5
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_n && ctrl_strb_n && !adv_n && act_q) |=> cnt_q == $past(cnt_q) + 2'd1);

endmodule

// File: rtl/burst_wr_decode.sv
module burst_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             adv_n,
  input  logic             glob_wr_n,
  input  logic             bw_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_mask
);
  logic eligible;

  assign eligible = proc_strb_n && (!ctrl_strb_n || !adv_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g] = eligible && (!glob_wr_n || (!bw_en_n && !lane_wr_n[g]));
  end

endmodule

// File: rtl/burst_mem_array.sv
module burst_mem_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  acc_mask,
  input  logic [DATA_W-1:0] acc_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
  logic [LANES-1:0]             lane_ok_q [DEPTH];
  logic [LANES-1:0][LANE_W-1:0] rd_word_d;
  logic [DATA_W-1:0]            rd_data_q;
  logic                         rd_vld_q, rd_vld_d, wr_go;

  assign wr_go    = acc_vld && (|acc_mask);
  assign rd_vld_d = acc_vld && !(|acc_mask);

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int i = 0; i < LANES; i++) begin
        if (acc_mask[i]) mem[acc_addr][i] <= acc_data[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) lane_ok_q[w] <= '0;
    end else if (wr_go) begin
      lane_ok_q[acc_addr] <= lane_ok_q[acc_addr] | acc_mask;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rd_word_d[i] = lane_ok_q[acc_addr][i] ? mem[acc_addr][i] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_vld_q  <= 1'b0;
    end else begin
      rd_vld_q <= rd_vld_d;
      if (rd_vld_d) rd_data_q <= rd_word_d;
    end
  end

  assign rd_data = rd_data_q;
  assign rd_vld  = rd_vld_q;

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !rd_vld);

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && (|acc_mask)) |=> !rd_vld);

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              adv_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              burst_linear,
  input  logic              glob_wr_n,
  input  logic              bw_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_en_o
);
  logic              sel_ok, acc_open;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_mask, mask_d;
  logic              acc_vld_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic [LANES-1:0]  acc_mask_q;
  logic [DATA_W-1:0] acc_data_q, rd_data;
  logic              rd_vld;

  assign sel_ok = !sel_n && sel_hi;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk, .rst_n, .addr_i, .proc_strb_n, .ctrl_strb_n, .adv_n,
    .sel_ok, .linear(burst_linear), .acc_addr, .acc_open
  );

  burst_wr_decode #(.LANES(LANES)) u_wdec (
    .proc_strb_n, .ctrl_strb_n, .adv_n, .glob_wr_n, .bw_en_n, .lane_wr_n,
    .lane_mask
  );

  assign mask_d = acc_open ? lane_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld_q  <= 1'b0;
      acc_addr_q <= '0;
      acc_mask_q <= '0;
      acc_data_q <= '0;
    end else begin
      acc_vld_q  <= acc_open;
      acc_addr_q <= acc_addr;
      acc_mask_q <= mask_d;
      if (|mask_d) acc_data_q <= wr_data;
    end
  end

  burst_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk, .rst_n, .acc_vld(acc_vld_q), .acc_addr(acc_addr_q),
    .acc_mask(acc_mask_q), .acc_data(acc_data_q), .rd_data, .rd_vld
  );

  assign rd_en_o = rd_vld && !oe_n;
  assign rd_q    = rd_en_o ? rd_data : {DATA_W{1'bz}};

  // R2
  proc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_strb_n |=> acc_mask_q == '0);

  // R8
  glob_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_n && !ctrl_strb_n && sel_ok && !glob_wr_n) |=> acc_mask_q == '1);

  // R10
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!proc_strb_n || !ctrl_strb_n) && !sel_ok) |=> !acc_vld_q);

endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int CLK_P = 10;
  localparam int NV    = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr_i;
  logic        proc_strb_n, ctrl_strb_n, adv_n, sel_n, sel_hi, burst_linear;
  logic        glob_wr_n, bw_en_n, oe_n;
  logic [3:0]  lane_wr_n;
  logic [35:0] wr_data;
  wire  [35:0] rd_q;
  wire         rd_en_o;

  burst_sram dut (
    .clk, .rst_n, .addr_i, .proc_strb_n, .ctrl_strb_n, .adv_n, .sel_n, .sel_hi,
    .burst_linear, .glob_wr_n, .bw_en_n, .lane_wr_n, .wr_data, .oe_n,
    .rd_q, .rd_en_o
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [35:0] ref_mem [256];
  logic [7:0]  m_base;
  logic [1:0]  m_cnt;
  bit          m_act;
  bit          prev_drive;
  logic [35:0] prev_val;
  int          prev_req;

  // fields: req[57:54] op[53:52] sel[51] addr[50:43] lin[42] g_n[41] b_n[40] l_n[39:36] data[35:0]
  // op: 0 processor strobe, 1 controller strobe, 2 advance, 3 hold
  localparam logic [57:0] VEC [NV] = '{
    {4'd8,  2'd1, 1'b1, 8'h10, 1'b1, 1'b0, 1'b1, 4'hF, 36'h1_1111_1111}, // R8 global write
    {4'd8,  2'd2, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 36'h2_2222_2222}, // R8 with lanes also low
    {4'd9,  2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 4'hA, 36'h9_ABCD_EF01}, // R9 lanes 0 and 2
    {4'd12, 2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 4'hF, 36'h3_3333_3333}, // R12 no lane: read zero
    {4'd2,  2'd0, 1'b1, 8'h10, 1'b1, 1'b0, 1'b1, 4'h0, 36'h4_4444_4444}, // R2 write ignored
    {4'd4,  2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 36'h0},           // R4
    {4'd9,  2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 36'h0},           // R9 merged word
    {4'd7,  2'd3, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 4'h0, 36'h5_5555_5555}, // R7 hold ignores write
    {4'd5,  2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 36'h0},           // R5
    {4'd5,  2'd2, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 36'h0},           // R5 wrap
    {4'd3,  2'd1, 1'b1, 8'h20, 1'b1, 1'b1, 1'b1, 4'hF, 36'h0},           // R3 read start
    {4'd9,  2'd1, 1'b1, 8'h12, 1'b1, 1'b1, 1'b1, 4'h0, 36'h6_6666_6666}, // R9 byte enable off
    {4'd10, 2'd1, 1'b0, 8'h30, 1'b1, 1'b0, 1'b1, 4'h0, 36'h7_7777_7777}, // R10 deselect
    {4'd10, 2'd2, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 4'h0, 36'h8_8888_8888}, // R10 adv while idle
    {4'd10, 2'd3, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'hF, 36'h0}            // R10 stays idle
  };

  task automatic check_out(input bit exp_drive, input logic [35:0] exp_val, input int req);
    checks++;
    if (rd_en_o !== exp_drive || (exp_drive && rd_q !== exp_val)) begin
      failures++;
      $display("FAIL R%0d: rd_en_o=%b rd_q=%h expected en=%b data=%h",
               req, rd_en_o, rd_q, exp_drive, exp_val);
    end
  endtask

  task automatic do_cyc(input int op, input bit sel, input logic [7:0] a, input bit lin,
                        input bit g_n, input bit b_n, input logic [3:0] l_n,
                        input logic [35:0] d, input int req);
    logic [1:0]  off;
    logic [7:0]  ea;
    logic [3:0]  mask;
    bit          cur_drive;
    logic [35:0] cur_val;
    if (op == 0 || op == 1) begin
      m_act = sel; m_base = a; m_cnt = 2'd0;
    end else if (op == 2 && m_act) begin
      m_cnt = m_cnt + 2'd1;
    end
    off  = lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    ea   = {m_base[7:2], off};
    mask = (op == 1 || op == 2) ? (!g_n ? 4'hF : (!b_n ? ~l_n : 4'h0)) : 4'h0;
    cur_val = '0;
    cur_drive = 0;
    if (m_act) begin
      if (mask != 0) begin
        for (int i = 0; i < 4; i++)
          if (mask[i]) ref_mem[ea][i*9 +: 9] = d[i*9 +: 9];
      end else begin
        cur_drive = 1;
        cur_val   = ref_mem[ea];
      end
    end
    proc_strb_n = !(op == 0); ctrl_strb_n = !(op == 1); adv_n = !(op == 2);
    sel_n = !sel; sel_hi = sel; addr_i = a; burst_linear = lin;
    glob_wr_n = g_n; bw_en_n = b_n; lane_wr_n = l_n; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    check_out(prev_drive, prev_val, prev_req);
    prev_drive = cur_drive; prev_val = cur_val; prev_req = req;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R1: watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 256; w++) ref_mem[w] = '0;
    m_base = '0; m_cnt = '0; m_act = 0;
    prev_drive = 0; prev_val = '0; prev_req = 1;
    rst_n = 0; addr_i = '0; proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
    sel_n = 0; sel_hi = 1; burst_linear = 1; glob_wr_n = 1; bw_en_n = 1;
    lane_wr_n = '1; wr_data = '0; oe_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_out(0, '0, 1);
    do_cyc(3, 1, 8'h00, 1, 1, 1, 4'hF, '0, 1); // R1 hold with nothing open

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_cyc(int'(VEC[v][53:52]), VEC[v][51], VEC[v][50:43], VEC[v][42],
             VEC[v][41], VEC[v][40], VEC[v][39:36], VEC[v][35:0], int'(VEC[v][57:54]));
    end

    // fill group 0x40..0x43 with distinct words (R3 write start, R8)
    do_cyc(1, 1, 8'h40, 1, 0, 1, 4'hF, 36'hA_0000_0A00, 3);
    for (int k = 1; k < 4; k++)
      do_cyc(2, 1, 8'h00, 1, 0, 1, 4'hF, 36'hA_0000_0A00 + 36'(k), 8);

    // R5 linear and R6 interleaved orders from every start, including wrap
    for (int md = 0; md < 2; md++) begin
      for (int st = 0; st < 4; st++) begin
        do_cyc(0, 1, 8'h40 + 8'(st), md[0], 1, 1, 4'hF, '0, md ? 5 : 6);
        for (int k = 0; k < 4; k++)
          do_cyc(2, 1, 8'h00, md[0], 1, 1, 4'hF, '0, md ? 5 : 6);
      end
    end

    // R11 asynchronous output enable
    do_cyc(0, 1, 8'h41, 1, 1, 1, 4'hF, '0, 4);
    do_cyc(3, 1, 8'h00, 1, 1, 1, 4'hF, '0, 7);
    oe_n = 1;
    #1;
    check_out(0, '0, 11);
    oe_n = 0;
    #1;
    check_out(1, ref_mem[8'h41], 11);
    do_cyc(3, 1, 8'h00, 1, 1, 1, 4'hF, '0, 7);

    // R10 deselect in the middle of a burst, then R12 on an untouched word
    do_cyc(0, 0, 8'h42, 1, 1, 1, 4'hF, '0, 10);
    do_cyc(2, 1, 8'h00, 1, 1, 1, 4'hF, '0, 10);
    do_cyc(1, 1, 8'hF7, 0, 1, 1, 4'hF, '0, 12);
    do_cyc(3, 0, 8'h00, 0, 1, 1, 4'hF, '0, 12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule